// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit forms the operand address of an 8-bit processor instruction from its addressing mode, its operand bytes, the two index registers and the address of the opcode. It also works out the extra cycles the instruction costs when indexing moves the access onto another 256-byte page. Instruction decode, the ALU and the register file are outside this block. The instruction sequencer pulses `start` with all inputs valid. It then waits for `done`, which marks the cycle in which `effAddr`, `pageCross` and `extraCycles` are valid. Those outputs hold until the next request completes.

Modes that fetch a 16-bit pointer from memory use a simple synchronous read port. The unit issues one byte read per cycle, low byte first, and the data comes back one cycle after the request. The unit keeps two hardware quirks. The pointer's high byte is always read from inside the same page as its low byte. For the indirect jump this gives the familiar wrap bug when the pointer ends in 0xFF. The same unit also handles relative branches: from the taken decision and the signed displacement in `opLo`, it returns the next program counter and the branch cycle penalty.

Top module: `effAddrUnit`

## Requirements
- R1: Zero page X (code 2) and zero page Y (code 3) add the index to `opLo` modulo 256, so the address always lies in page zero.
- R2: `mode` is a 4-bit code: 0 immediate, 1 zero page, 2 zero page X, 3 zero page Y, 4 absolute, 5 absolute X, 6 absolute Y, 7 indirect jump, 8 indexed indirect X, 9 indirect indexed Y, 10 relative branch. Immediate gives `pc`+1, zero page gives {0x00,`opLo`}, absolute gives {`opHi`,`opLo`}, and none of these three flags a page cross.
- R3: Absolute X and absolute Y add the index to the full 16-bit base {`opHi`,`opLo`}, with 16-bit wrap. `pageCross` is set exactly when the sum's upper byte differs from the base's upper byte.
- R4: Indexed indirect X reads its pointer low byte at zero-page address (`opLo`+X) mod 256 and its high byte at that address plus one, still mod 256. The pointer is the result and flags no page cross.
- R5: Indirect indexed Y reads its pointer at `opLo` and at (`opLo`+1) mod 256, then adds Y with 16-bit wrap. It flags a page cross when the upper byte of the sum differs from that of the pointer.
- R6: The indirect jump reads the pointer low byte at {`opHi`,`opLo`} and the high byte at {`opHi`,(`opLo`+1) mod 256}, so a pointer ending in 0xFF takes its high byte from the start of the same page.
- R7: Outside branches, `extraCycles` is 1 when `pageCross` is set and `penalize` was high at `start`, and 0 otherwise.
- R8: A branch result is the following instruction address `pc`+2 when `brTaken` is low. When `brTaken` is high it is `pc`+2 plus the sign-extended `opLo`, with 16-bit wrap.
- R9: A branch that is not taken costs 0 extra cycles. A taken branch costs 1, or 2 when its target's upper byte differs from that of `pc`+2; `pageCross` reports that difference. `penalize` has no effect on branches.
- R10: `done` rises one clock after the edge that samples `start` for modes without a pointer, and three clocks after it for codes 7, 8 and 9. Pointer modes issue exactly two reads, on consecutive cycles, low byte address first. No other mode reads.
- R11: After reset, `done`, `memRdEn`, `pageCross`, `extraCycles` and `effAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| mode | input | 4 | Addressing mode code |
| opLo | input | 8 | First operand byte or branch displacement |
| opHi | input | 8 | Second operand byte |
| idxX | input | 8 | X index value |
| idxY | input | 8 | Y index value |
| pc | input | 16 | Address of the opcode byte |
| brTaken | input | 1 | Branch condition met |
| penalize | input | 1 | Operation pays the page-cross cycle |
| memRdEn | output | 1 | Byte read request |
| memAddr | output | 16 | Byte read address |
| memRdData | input | 8 | Read data, one cycle after the request |
| done | output | 1 | Result valid pulse |
| effAddr | output | 16 | Effective address or next program counter |
| pageCross | output | 1 | Page crossing detected |
| extraCycles | output | 2 | Extra cycles owed |

## Verification
The pointer wrap inside a page and the page crossing caused by indexing can both happen in one indirect-Y lookup. This is provoked with a pointer byte at 0xFF and a Y value that carries the fetched pointer into the next page. A single `done` pulse is then judged on the reported read addresses, the final address, the cross flag and the cycle count, all together. The same sweep also covers taken branches whose target and the following instruction sit on either side of a page boundary, both forward and backward. A case that lands exactly on the next page start from the following instruction shows that the comparison uses `pc`+2 and not `pc`.

// File: rtl/effAddrPkg.sv
package effAddrPkg;

  typedef enum logic [3:0] {
    MODE_IMM  = 4'd0,
    MODE_ZP   = 4'd1,
    MODE_ZPX  = 4'd2,
    MODE_ZPY  = 4'd3,
    MODE_ABS  = 4'd4,
    MODE_ABSX = 4'd5,
    MODE_ABSY = 4'd6,
    MODE_IND  = 4'd7,
    MODE_INDX = 4'd8,
    MODE_INDY = 4'd9,
    MODE_REL  = 4'd10
  } addrMode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchIn;   // capture request inputs
    logic rdLo;      // read pointer low byte
    logic rdHi;      // read pointer high byte
    logic ldPtrLo;   // store returned low byte
    logic capture;   // register final results
  } eaStrobe_t;

  function automatic logic usesPointer(addrMode_e m);
    return (m == MODE_IND) || (m == MODE_INDX) || (m == MODE_INDY);
  endfunction

endpackage

// File: rtl/effAddrControl.sv
module effAddrControl
  import effAddrPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  addrMode_e modeIn,
  output eaStrobe_t strobe,
  output logic      done
);

  typedef enum logic [1:0] {S_IDLE, S_RDLO, S_RDHI, S_CALC} ctlState_e;

  ctlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (start) stateNext = usesPointer(modeIn) ? S_RDLO : S_CALC;
      S_RDLO: stateNext = S_RDHI;
      S_RDHI: stateNext = S_CALC;
      S_CALC: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.latchIn = (state == S_IDLE) && start;
    strobe.rdLo    = (state == S_RDLO);
    strobe.rdHi    = (state == S_RDHI);
    strobe.ldPtrLo = (state == S_RDHI);
    strobe.capture = (state == S_CALC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.capture;
    end
  end

endmodule

// File: rtl/effAddrDatapath.sv
module effAddrDatapath
  import effAddrPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  eaStrobe_t             strobe,
  input  addrMode_e             modeIn,
  input  logic [BYTE_W-1:0]     opLoIn,
  input  logic [BYTE_W-1:0]     opHiIn,
  input  logic [BYTE_W-1:0]     idxXIn,
  input  logic [BYTE_W-1:0]     idxYIn,
  input  logic [2*BYTE_W-1:0]   pcIn,
  input  logic                  brTakenIn,
  input  logic                  penalizeIn,
  input  logic [BYTE_W-1:0]     memRdData,
  output logic [2*BYTE_W-1:0]   memAddr,
  output addrMode_e             modeQ,
  output logic [2*BYTE_W-1:0]   effAddr,
  output logic                  pageCross,
  output logic [1:0]            extraCycles
);

  localparam int ADDR_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] BYTE_ONE = BYTE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_TWO = ADDR_W'(2);
  localparam logic [BYTE_W-1:0] PAGE_ZERO = '0;

  // Latched request
  addrMode_e          modeR;
  logic [BYTE_W-1:0]  opLoR, opHiR, xR, yR, ptrLoR;
  logic [ADDR_W-1:0]  pcR;
  logic               takenR, penR;

  // Intermediate values
  logic [BYTE_W-1:0]  idxSel, zpSum, ptrLowInc;
  logic [ADDR_W-1:0]  absBase, absSum, ptrBase, ptrNext, ptrWord, indySum;
  logic [ADDR_W-1:0]  nextPc, dispExt, brTarget;
  logic [ADDR_W-1:0]  nAddr;
  logic               nCross;
  logic [1:0]         nExtra;

  assign idxSel    = (modeR == MODE_ZPY || modeR == MODE_ABSY) ? yR : xR;
  assign zpSum     = opLoR + idxSel;
  assign absBase   = {opHiR, opLoR};
  assign absSum    = absBase + {PAGE_ZERO, idxSel};

  always_comb begin
    unique case (modeR)
      MODE_IND:  ptrBase = {opHiR, opLoR};
      MODE_INDX: ptrBase = {PAGE_ZERO, opLoR + xR};
      default:   ptrBase = {PAGE_ZERO, opLoR};
    endcase
  end

  // High byte of a pointer never leaves the page of its low byte
  assign ptrLowInc = ptrBase[BYTE_W-1:0] + BYTE_ONE;
  assign ptrNext   = {ptrBase[ADDR_W-1:BYTE_W], ptrLowInc};
  assign memAddr   = strobe.rdHi ? ptrNext : ptrBase;

  // High pointer byte arrives during the result cycle
  assign ptrWord   = {memRdData, ptrLoR};
  assign indySum   = ptrWord + {PAGE_ZERO, yR};

  assign nextPc    = pcR + ADDR_TWO;
  assign dispExt   = {{BYTE_W{opLoR[BYTE_W-1]}}, opLoR};
  assign brTarget  = nextPc + dispExt;

  always_comb begin
    nAddr  = pcR + ADDR_ONE;
    nCross = 1'b0;
    unique case (modeR)
      MODE_IMM:  nAddr = pcR + ADDR_ONE;
      MODE_ZP:   nAddr = {PAGE_ZERO, opLoR};
      MODE_ZPX,
      MODE_ZPY:  nAddr = {PAGE_ZERO, zpSum};
      MODE_ABS:  nAddr = absBase;
      MODE_ABSX,
      MODE_ABSY: begin
        nAddr  = absSum;
        nCross = absSum[ADDR_W-1:BYTE_W] != absBase[ADDR_W-1:BYTE_W];
      end
      MODE_IND,
      MODE_INDX: nAddr = ptrWord;
      MODE_INDY: begin
        nAddr  = indySum;
        nCross = indySum[ADDR_W-1:BYTE_W] != ptrWord[ADDR_W-1:BYTE_W];
      end
      MODE_REL: begin
        nAddr  = takenR ? brTarget : nextPc;
        nCross = takenR && (brTarget[ADDR_W-1:BYTE_W] != nextPc[ADDR_W-1:BYTE_W]);
      end
      default: nAddr = pcR + ADDR_ONE;
    endcase
  end

  always_comb begin
    if (modeR == MODE_REL)
      nExtra = takenR ? (nCross ? 2'd2 : 2'd1) : 2'd0;
    else
      nExtra = {1'b0, nCross & penR};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR       <= MODE_IMM;
      opLoR       <= '0;
      opHiR       <= '0;
      xR          <= '0;
      yR          <= '0;
      pcR         <= '0;
      takenR      <= 1'b0;
      penR        <= 1'b0;
      ptrLoR      <= '0;
      effAddr     <= '0;
      pageCross   <= 1'b0;
      extraCycles <= 2'd0;
    end else begin
      if (strobe.latchIn) begin
        modeR  <= modeIn;
        opLoR  <= opLoIn;
        opHiR  <= opHiIn;
        xR     <= idxXIn;
        yR     <= idxYIn;
        pcR    <= pcIn;
        takenR <= brTakenIn;
        penR   <= penalizeIn;
      end
      if (strobe.ldPtrLo) ptrLoR <= memRdData;
      if (strobe.capture) begin
        effAddr     <= nAddr;
        pageCross   <= nCross;
        extraCycles <= nExtra;
      end
    end
  end

  assign modeQ = modeR;

endmodule

// File: rtl/effAddrUnit.sv
module effAddrUnit
  import effAddrPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           mode,
  input  logic [BYTE_W-1:0]    opLo,
  input  logic [BYTE_W-1:0]    opHi,
  input  logic [BYTE_W-1:0]    idxX,
  input  logic [BYTE_W-1:0]    idxY,
  input  logic [2*BYTE_W-1:0]  pc,
  input  logic                 brTaken,
  input  logic                 penalize,
  output logic                 memRdEn,
  output logic [2*BYTE_W-1:0]  memAddr,
  input  logic [BYTE_W-1:0]    memRdData,
  output logic                 done,
  output logic [2*BYTE_W-1:0]  effAddr,
  output logic                 pageCross,
  output logic [1:0]           extraCycles
);

  addrMode_e modeEnum;
  addrMode_e modeQ;
  eaStrobe_t strobe;

  assign modeEnum = addrMode_e'(mode);
  assign memRdEn  = strobe.rdLo | strobe.rdHi;

  effAddrControl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .modeIn (modeEnum),
    .strobe (strobe),
    .done   (done)
  );

  effAddrDatapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .modeIn      (modeEnum),
    .opLoIn      (opLo),
    .opHiIn      (opHi),
    .idxXIn      (idxX),
    .idxYIn      (idxY),
    .pcIn        (pc),
    .brTakenIn   (brTaken),
    .penalizeIn  (penalize),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .modeQ       (modeQ),
    .effAddr     (effAddr),
    .pageCross   (pageCross),
    .extraCycles (extraCycles)
  );

endmodule

// File: rtl/effAddrUnitChecker.sv
module effAddrUnitChecker
  import effAddrPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                done,
  input logic                memRdEn,
  input logic [2*BYTE_W-1:0] memAddr,
  input logic [2*BYTE_W-1:0] effAddr,
  input logic                pageCross,
  input logic [1:0]          extraCycles,
  input addrMode_e           modeQ
);

  localparam int ADDR_W = 2 * BYTE_W;

  // R1: indexed zero-page results never leave page zero
  a_r1_zp_page_zero: assert property (@(posedge clk) disable iff (!rstN)
    done && (modeQ == MODE_ZPX || modeQ == MODE_ZPY || modeQ == MODE_ZP)
      |-> effAddr[ADDR_W-1:BYTE_W] == '0);

  // R6: the second pointer read stays in the page of the first
  a_r6_hi_read_same_page: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && !$past(memRdEn)
      |=> memRdEn
          && memAddr[ADDR_W-1:BYTE_W] == $past(memAddr[ADDR_W-1:BYTE_W])
          && memAddr[BYTE_W-1:0] == BYTE_W'($past(memAddr[BYTE_W-1:0]) + 1));

  // R7: outside branches at most one extra cycle, and only with a cross
  a_r7_single_penalty: assert property (@(posedge clk) disable iff (!rstN)
    done && modeQ != MODE_REL
      |-> extraCycles <= 2'd1 && (extraCycles == 2'd0 || pageCross));

  // R9: a taken branch pays two cycles exactly when it crosses
  a_r9_branch_cost: assert property (@(posedge clk) disable iff (!rstN)
    done && modeQ == MODE_REL
      |-> (pageCross ? extraCycles == 2'd2 : extraCycles <= 2'd1));

  // R10: reads come in pairs and never run into a third cycle
  a_r10_read_pair: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) |=> !memRdEn);

  // R10: no read is pending while the result is presented
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRdEn);

endmodule

bind effAddrUnit effAddrUnitChecker #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .done        (done),
  .memRdEn     (memRdEn),
  .memAddr     (memAddr),
  .effAddr     (effAddr),
  .pageCross   (pageCross),
  .extraCycles (extraCycles),
  .modeQ       (modeQ)
);

// File: tb/effAddrUnit_bench.sv
`timescale 1ns/1ps
module effAddrUnit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opLo = '0, opHi = '0, idxX = '0, idxY = '0;
  logic [15:0] pc = '0;
  logic        brTaken = 1'b0, penalize = 1'b0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData = '0;
  logic        done;
  logic [15:0] effAddr;
  logic        pageCross;
  logic [1:0]  extraCycles;

  int nChecks = 0;
  int nErr = 0;
  int rdCnt = 0;
  int rdLog [4];
  bit finished = 0;

  always #5 clk = ~clk;

  effAddrUnit u_effAddrUnit (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .opLo(opLo),
    .opHi(opHi), .idxX(idxX), .idxY(idxY), .pc(pc), .brTaken(brTaken),
    .penalize(penalize), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .done(done), .effAddr(effAddr),
    .pageCross(pageCross), .extraCycles(extraCycles)
  );

  function automatic int memByte(int a);
    return ((a & 255) ^ ((a >> 8) & 255) ^ 8'h5A) & 255;
  endfunction

  // Synchronous read port with a computed content
  always @(posedge clk) begin
    if (memRdEn) memRdData <= 8'(memByte(int'(memAddr)));
    if (rstN && memRdEn) begin
      if (rdCnt < 4) rdLog[rdCnt] = int'(memAddr);
      rdCnt = rdCnt + 1;
    end
  end

  function automatic string addrTag(int m);
    case (m)
      2, 3:    return "R1";
      5, 6:    return "R3";
      8:       return "R4";
      9:       return "R5";
      7:       return "R6";
      10:      return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic string crossTag(int m);
    if (m == 10) return "R9";
    if (m == 9) return "R5";
    return (m == 5 || m == 6) ? "R3" : addrTag(m);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  task automatic runOp(int m, int lo, int hi, int x, int y, int p, int tk, int pen);
    int expAddr, expCross, expExtra, expLat, nRd, rd0, rd1, base, nxt, d, t, lat;
    expCross = 0; expExtra = 0; nRd = 0; rd0 = 0; rd1 = 0;
    case (m)
      0: expAddr = (p + 1) & 16'hFFFF;
      1: expAddr = lo;
      2: expAddr = (lo + x) & 255;
      3: expAddr = (lo + y) & 255;
      4: expAddr = hi * 256 + lo;
      5, 6: begin
        base = hi * 256 + lo;
        expAddr = (base + (m == 5 ? x : y)) & 16'hFFFF;
        expCross = int'((base >> 8) != (expAddr >> 8));
      end
      7: begin
        nRd = 2; rd0 = hi * 256 + lo; rd1 = hi * 256 + ((lo + 1) & 255);
        expAddr = memByte(rd1) * 256 + memByte(rd0);
      end
      8: begin
        nRd = 2; rd0 = (lo + x) & 255; rd1 = (rd0 + 1) & 255;
        expAddr = memByte(rd1) * 256 + memByte(rd0);
      end
      9: begin
        nRd = 2; rd0 = lo; rd1 = (lo + 1) & 255;
        base = memByte(rd1) * 256 + memByte(rd0);
        expAddr = (base + y) & 16'hFFFF;
        expCross = int'((base >> 8) != (expAddr >> 8));
      end
      default: begin
        nxt = (p + 2) & 16'hFFFF;
        d = (lo >= 128) ? lo - 256 : lo;
        t = (nxt + d) & 16'hFFFF;
        expAddr = tk ? t : nxt;
        expCross = tk ? int'((t >> 8) != (nxt >> 8)) : 0;
      end
    endcase
    if (m == 10) expExtra = tk ? (expCross ? 2 : 1) : 0;
    else expExtra = expCross & pen;
    expLat = (nRd != 0) ? 4 : 2;

    @(negedge clk);
    mode = 4'(m); opLo = 8'(lo); opHi = 8'(hi); idxX = 8'(x); idxY = 8'(y);
    pc = 16'(p); brTaken = tk[0]; penalize = pen[0];
    rdCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R10", "latency", lat, expLat);
    chk(addrTag(m), "effAddr", int'(effAddr), expAddr);
    chk(crossTag(m), "pageCross", int'(pageCross), expCross);
    chk(m == 10 ? "R9" : "R7", "extraCycles", int'(extraCycles), expExtra);
    chk("R10", "read count", rdCnt, nRd);
    if (nRd == 2) begin
      chk(addrTag(m), "pointer low read", rdLog[0], rd0);
      chk(addrTag(m), "pointer high read", rdLog[1], rd1);
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int loList [4] = '{0, 1, 128, 255};
    int hiList [3] = '{8'h00, 8'h30, 8'hFF};
    int ixList [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
    int pcList [5] = '{16'h10F0, 16'h1000, 16'h10FE, 16'hFFFE, 16'h2080};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "done", int'(done), 0);
    chk("R11", "memRdEn", int'(memRdEn), 0);
    chk("R11", "effAddr", int'(effAddr), 0);
    chk("R11", "pageCross", int'(pageCross), 0);
    chk("R11", "extraCycles", int'(extraCycles), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "done after release", int'(done), 0);

    // Named corners
    runOp(7, 8'hFF, 8'h30, 0, 0, 16'h0400, 0, 1);       // R6 wrap bug
    runOp(9, 8'hFF, 8'h00, 0, 8'h60, 16'h0400, 0, 1);   // R5 wrap plus cross
    runOp(8, 8'hF0, 8'h00, 8'h0F, 0, 16'h0400, 0, 0);   // R4 pointer at 0xFF
    runOp(10, 8'h20, 0, 0, 0, 16'h10F0, 1, 0);          // R9 forward cross
    runOp(10, 8'h80, 0, 0, 0, 16'h1000, 1, 0);          // R9 backward cross
    runOp(10, 8'h00, 0, 0, 0, 16'h10FE, 1, 1);          // R9 same page as pc+2
    runOp(5, 8'hF0, 8'h12, 8'h20, 0, 16'h0000, 0, 0);   // R7 cross, no penalty

    // Sweep of non-branch modes
    for (int m = 0; m < 10; m++)
      for (int i = 0; i < 16; i++)
        for (int h = 0; h < 3; h++)
          for (int k = 0; k < 4; k++)
            runOp(m, (i * 17) & 255, hiList[h], ixList[k], ixList[(k + 1) & 3],
                  (hiList[h] << 8) | ((i * 17) ^ 8'hC3), (i + k) & 1, (i + h + k) & 1);

    // Branch sweep: R8 and R9, penalize toggled to show it has no effect
    for (int q = 0; q < 5; q++)
      for (int i = 0; i < 16; i++)
        for (int tk = 0; tk < 2; tk++)
          runOp(10, (i * 17 + loList[q & 3]) & 255, 0, 0, 0, pcList[q], tk, i & 1);

    finish();
  end

endmodule